// File: doc/BRIEF.md
# Serial Coefficient and Control Register Loader

This block fills the coefficient memory and the rounding and limit registers of an image filter datapath over a narrow 12-bit load bus. A load session opens when the active-low load enable falls. The first word sampled is an address. The next four words are data. When the fourth data word arrives, the group is committed as a single write to one of three register spaces.

A coefficient set address produces a single-cycle write strobe toward four 12-bit coefficient banks. Each bank receives one of the four data words. A rounding or limit register address builds a 32-bit value from the low bytes of the four data words and updates the addressed register in one step. After a commit, the next word is taken as a new address, so groups can follow one another without gaps for as long as the enable stays low.

The load bus has no back-pressure. A word is consumed on every rising clock edge while the session is armed. The enable level is the only qualifier, so the block needs no valid/ready pair. Releasing the enable mid-group drops the partial group. A fresh falling edge of the enable is then needed before loading resumes.

Top module: `coef_loader`

## Requirements
- R1: The load bus is sampled on rising edges of `ld_clk` only while `load_en_n` is 0. While `load_en_n` is 1, bus activity changes no output.
- R2: Loading is armed only by a 1-to-0 transition of `load_en_n` seen at a clock edge. An enable that is already 0 when reset ends does not arm, and words sent that way write nothing.
- R3: A group is one address word followed by four data words. No write becomes visible before the edge that samples the fourth data word.
- R4: Addresses 000h to 0FFh commit a coefficient set. In the cycle after the fourth data word, `bank_we` is 1 for exactly one cycle. `bank_addr` holds the address bits 7:0. Bank k (`bank_wdata` bits 12k+11:12k) holds data word k, where word 0 is the first word after the address.
- R5: After the fourth data word, the next sampled word is treated as a new address, so groups run back to back without releasing the enable.
- R6: Addresses 800h to 80Fh write rounding register n (address bits 3:0), which appears on `rnd_regs` bits 32n+31:32n. Register bits 8k+7:8k come from bits 7:0 of data word k. The register updates at the edge of the fourth data word.
- R7: Addresses C00h to C0Fh write limit register n on `lmt_regs` bits 32n+31:32n. The packing is the same as in R6, so the upper limit (bits 31:16) comes from data words 2 and 3, and the lower limit (bits 15:0) comes from data words 0 and 1.
- R8: An address outside the three ranges still consumes four data words. It then writes nothing and raises no strobe.
- R9: Setting `load_en_n` to 1 before the fourth data word discards the partial group. The next word after a new falling edge is an address.
- R10: Reset clears `bank_we`, `bank_addr`, `bank_wdata` and every rounding and limit register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en_n | input | 1 | Active-low load enable; its falling edge arms a session |
| load_bus | input | 12 | Address and data words |
| bank_we | output | 1 | One-cycle coefficient set write strobe |
| bank_addr | output | 8 | Coefficient set index |
| bank_wdata | output | 48 | Four 12-bit bank words, bank 0 in the low bits |
| rnd_regs | output | 512 | Sixteen 32-bit rounding registers |
| lmt_regs | output | 512 | Sixteen 32-bit limit registers, upper limit in bits 31:16 |

## Verification
Two events can fall on the same clock edge:
- the commit of one group and the capture of the next group's address word, when groups run back to back;
- the arming edge of the enable and the capture of the first address, when a session opens.

The bench provokes the first by chaining up to four random groups of mixed type inside one enabled session. For each group it checks that the committed value matches its own data and that the following word is decoded as an address. It provokes the second by dropping the enable in the same cycle the address is driven, including directly after a mid-group abort. Each result is judged against a register model kept in the bench, one cycle after the fourth data word.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_COEF,
    TGT_RND,
    TGT_LMT
  } tgt_e;

  // Map an address word onto one of the three register spaces.
  function automatic tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
    if (a[11:8] == 4'h0)       return TGT_COEF;
    else if (a[11:4] == 8'h80) return TGT_RND;
    else if (a[11:4] == 8'hC0) return TGT_LMT;
    else                       return TGT_NONE;
  endfunction
endpackage

// File: rtl/ld_arm.sv
module ld_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  output logic accept
);
  // Enable level seen at the previous edge; starts low so a held-low enable cannot arm.
  logic prev_hi_q;
  logic armed_q;
  logic fall;

  assign fall   = prev_hi_q & ~en_n;
  assign accept = ~en_n & (armed_q | fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_hi_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      prev_hi_q <= en_n;
      armed_q   <= ~en_n & (armed_q | fall);
    end
  end

  // R2
  arm_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(prev_hi_q));

  // R9
  release_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !armed_q);
endmodule

// File: rtl/ld_seq.sv
module ld_seq #(
  parameter int DW = 12,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             accept,
  input  logic [DW-1:0]    din,
  output logic             done,
  output logic [DW-1:0]    grp_addr,
  output logic [NW*DW-1:0] grp_words
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] word_q [NW-1];

  // The last data word is taken straight from the bus so the commit lands on its edge.
  assign done     = accept && (cnt_q == CW'(NW));
  assign grp_addr = addr_q;

  generate
    for (genvar k = 0; k < NW - 1; k++) begin : g_words
      assign grp_words[k*DW +: DW] = word_q[k];
    end
  endgenerate
  assign grp_words[(NW-1)*DW +: DW] = din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      for (int k = 0; k < NW - 1; k++) word_q[k] <= '0;
    end else if (en_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= (cnt_q == CW'(NW)) ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0) addr_q <= din;
      for (int k = 0; k < NW - 1; k++)
        if (cnt_q == CW'(k + 1)) word_q[k] <= din;
    end
  end

  // R3
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_q == '0) |=> (cnt_q == CW'(1)));

  // R5
  wrap_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_q == CW'(NW)) |=> (cnt_q == '0));

  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> (cnt_q == '0));
endmodule

// File: rtl/ld_regs.sv
module ld_regs #(
  parameter int NREG = 16,
  parameter int RW   = 32,
  parameter int DW   = 12,
  parameter int NW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_rnd,
  input  logic                    we_lmt,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [NW*DW-1:0]        words,
  output logic [NREG*RW-1:0]      rnd_regs,
  output logic [NREG*RW-1:0]      lmt_regs
);
  localparam int BPW = RW / NW;
  localparam int IW  = $clog2(NREG);

  logic [RW-1:0] val;

  // Low byte of each data word, first word in the least significant position.
  always_comb begin
    for (int k = 0; k < NW; k++) val[k*BPW +: BPW] = words[k*DW +: BPW];
  end

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [RW-1:0] rnd_q;
      logic [RW-1:0] lmt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rnd_q <= '0;
          lmt_q <= '0;
        end else begin
          if (we_rnd && idx == IW'(r)) rnd_q <= val;
          if (we_lmt && idx == IW'(r)) lmt_q <= val;
        end
      end
      assign rnd_regs[r*RW +: RW] = rnd_q;
      assign lmt_regs[r*RW +: RW] = lmt_q;
    end
  endgenerate

  // R6
  rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_rnd |=> $stable(rnd_regs));

  // R7
  lmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lmt |=> $stable(lmt_regs));
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int NSET  = 256,
  parameter int NREG  = 16,
  parameter int RW    = 32
) (
  input  logic                         ld_clk,
  input  logic                         rst_n,
  input  logic                         load_en_n,
  input  logic [ADDR_W-1:0]            load_bus,
  output logic                         bank_we,
  output logic [$clog2(NSET)-1:0]      bank_addr,
  output logic [NBANK*ADDR_W-1:0]      bank_wdata,
  output logic [NREG*RW-1:0]           rnd_regs,
  output logic [NREG*RW-1:0]           lmt_regs
);
  localparam int SAW = $clog2(NSET);
  localparam int IW  = $clog2(NREG);

  logic                    accept;
  logic                    done;
  logic [ADDR_W-1:0]       grp_addr;
  logic [NBANK*ADDR_W-1:0] grp_words;
  tgt_e                    tgt;
  logic                    coef_wr;

  assign tgt     = decode_tgt(grp_addr);
  assign coef_wr = done && (tgt == TGT_COEF);

  ld_arm u_arm (
    .clk    (ld_clk),
    .rst_n  (rst_n),
    .en_n   (load_en_n),
    .accept (accept)
  );

  ld_seq #(.DW(ADDR_W), .NW(NBANK)) u_seq (
    .clk       (ld_clk),
    .rst_n     (rst_n),
    .en_n      (load_en_n),
    .accept    (accept),
    .din       (load_bus),
    .done      (done),
    .grp_addr  (grp_addr),
    .grp_words (grp_words)
  );

  ld_regs #(.NREG(NREG), .RW(RW), .DW(ADDR_W), .NW(NBANK)) u_regs (
    .clk      (ld_clk),
    .rst_n    (rst_n),
    .we_rnd   (done && (tgt == TGT_RND)),
    .we_lmt   (done && (tgt == TGT_LMT)),
    .idx      (grp_addr[IW-1:0]),
    .words    (grp_words),
    .rnd_regs (rnd_regs),
    .lmt_regs (lmt_regs)
  );

  always_ff @(posedge ld_clk) begin
    if (!rst_n) begin
      bank_we    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      bank_we <= coef_wr;
      if (coef_wr) begin
        bank_addr  <= grp_addr[SAW-1:0];
        bank_wdata <= grp_words;
      end
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    bank_we |=> !bank_we);

  // R8
  no_write_unmapped_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    (done && tgt == TGT_NONE) |=> (!bank_we && $stable(rnd_regs) && $stable(lmt_regs)));
endmodule

// File: tb/sim_coef_loader.sv
`timescale 1ns/1ps
module sim_coef_loader;
  logic         ld_clk = 1'b0;
  logic         rst_n;
  logic         load_en_n;
  logic [11:0]  load_bus;
  logic         bank_we;
  logic [7:0]   bank_addr;
  logic [47:0]  bank_wdata;
  logic [511:0] rnd_regs;
  logic [511:0] lmt_regs;

  int n_chk  = 0;
  int n_fail = 0;
  logic [511:0] m_rnd;
  logic [511:0] m_lmt;

  always #2.5 ld_clk = ~ld_clk;

  coef_loader u0 (
    .ld_clk(ld_clk), .rst_n(rst_n), .load_en_n(load_en_n), .load_bus(load_bus),
    .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .rnd_regs(rnd_regs), .lmt_regs(lmt_regs)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack32(input logic [11:0] w0, w1, w2, w3);
    return {w3[7:0], w2[7:0], w1[7:0], w0[7:0]};
  endfunction

  // 0 none, 1 coefficient, 2 rounding, 3 limit
  function automatic int kind(input logic [11:0] a);
    if (a <= 12'h0FF) return 1;
    if (a >= 12'h800 && a <= 12'h80F) return 2;
    if (a >= 12'hC00 && a <= 12'hC0F) return 3;
    return 0;
  endfunction

  function automatic logic [11:0] pick_addr();
    case ($urandom % 4)
      0:       return {4'h0, 8'($urandom)};
      1:       return {8'h80, 4'($urandom)};
      2:       return {8'hC0, 4'($urandom)};
      default: return 12'h100 + 12'($urandom % 12'h700);
    endcase
  endfunction

  task automatic put(input logic [11:0] d);
    load_en_n = 1'b0;
    load_bus  = d;
    @(negedge ld_clk);
  endtask

  task automatic chk_quiet(input string req);
    chk(!bank_we && rnd_regs == m_rnd && lmt_regs == m_lmt, req,
        {bank_we, rnd_regs[255:0], lmt_regs[254:0]}, {1'b0, m_rnd[255:0], m_lmt[254:0]});
  endtask

  task automatic group(input logic [11:0] a, w0, w1, w2, w3);
    put(a); put(w0); put(w1); put(w2);
    chk_quiet("R3");
    put(w3);
    case (kind(a))
      1: chk(bank_we && bank_addr == a[7:0] && bank_wdata == {w3, w2, w1, w0}, "R4",
             {bank_we, bank_addr, bank_wdata}, {1'b1, a[7:0], w3, w2, w1, w0});
      2: begin
        m_rnd[a[3:0]*32 +: 32] = pack32(w0, w1, w2, w3);
        chk(!bank_we && rnd_regs == m_rnd && lmt_regs == m_lmt, "R6", rnd_regs, m_rnd);
      end
      3: begin
        m_lmt[a[3:0]*32 +: 32] = pack32(w0, w1, w2, w3);
        chk(!bank_we && lmt_regs == m_lmt && rnd_regs == m_rnd
            && lmt_regs[a[3:0]*32+16 +: 16] == {w3[7:0], w2[7:0]}, "R7", lmt_regs, m_lmt);
      end
      default: chk_quiet("R8");
    endcase
  endtask

  task automatic release_chk();
    load_en_n = 1'b1;
    repeat (3) begin
      load_bus = 12'($urandom);
      @(negedge ld_clk);
      chk_quiet("R1");
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge ld_clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int seed;
    seed  = $urandom(32'd4711);
    m_rnd = '0;
    m_lmt = '0;
    rst_n = 1'b0;
    load_en_n = 1'b0;
    load_bus  = 12'h803;
    repeat (3) @(negedge ld_clk);
    chk(!bank_we && bank_addr == 0 && bank_wdata == 0 && rnd_regs == 0 && lmt_regs == 0, "R10",
        {bank_we, bank_addr, bank_wdata}, '0);
    rst_n = 1'b1;

    // R2: enable already low at reset, words must not load
    put(12'h803);
    for (int i = 0; i < 4; i++) begin
      put(12'h0A5);
      chk_quiet("R2");
    end
    put(12'h055);
    chk_quiet("R2");

    // R5: back-to-back groups of every kind in one session
    release_chk();
    group(12'h812, 12'h111, 12'h122, 12'h133, 12'h144);
    group(12'h042, 12'hABC, 12'hDEF, 12'h012, 12'h345);
    group(12'hC0F, 12'hF01, 12'hF02, 12'hF03, 12'hF04);
    group(12'h80F, 12'hE11, 12'hE22, 12'hE33, 12'hE44);
    chk(rnd_regs[15*32 +: 32] == 32'h44332211 && lmt_regs[15*32 +: 32] == 32'h04030201, "R5",
        {rnd_regs[15*32 +: 32], lmt_regs[15*32 +: 32]}, {32'h44332211, 32'h04030201});
    group(12'h0FF, 12'h001, 12'h002, 12'h003, 12'h004);
    group(12'h000, 12'hFFF, 12'hEEE, 12'hDDD, 12'hCCC);
    group(12'h810, 12'h777, 12'h777, 12'h777, 12'h777);
    group(12'hC10, 12'h777, 12'h777, 12'h777, 12'h777);

    // R9: abort mid-group, then a fresh edge starts at an address
    release_chk();
    put(12'h805); put(12'h0AA); put(12'h0BB);
    load_en_n = 1'b1;
    load_bus  = 12'h0CC;
    @(negedge ld_clk);
    chk_quiet("R9");
    group(12'h806, 12'h0A1, 12'h0B2, 12'h0C3, 12'h0D4);
    chk(rnd_regs[5*32 +: 32] == 32'h0 && rnd_regs[6*32 +: 32] == 32'hD4C3B2A1, "R9",
        rnd_regs[6*32 +: 64], {32'hD4C3B2A1, 32'h0});

    // random sessions of mixed groups
    for (int s = 0; s < 40; s++) begin
      int ng;
      release_chk();
      ng = 1 + int'($urandom % 4);
      for (int g = 0; g < ng; g++)
        group(pick_addr(), 12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
      if ($urandom % 3 == 0) begin
        put(12'h80A); put(12'($urandom));
        load_en_n = 1'b1;
        @(negedge ld_clk);
        chk_quiet("R9");
      end
    end
    release_chk();
    finish_run();
  end
endmodule